// File: doc/BRIEF.md
# SPI Register Front End (Status and Data)

This block sits between a CPU register bus and the bit-level shift engine of an 8-bit SPI peripheral. It keeps the receive buffer, the transmit byte and three status flags: transfer complete, write collision and mode fault. It updates the flags from shift-engine events and from bus accesses. The CPU reaches it through a single-cycle read or write strobe and a 2-bit register select. The shift engine reports a completed byte with a pulse and the received byte. It also reports a busy level and a mode-fault pulse. In return, the block gives the engine a transmit-start pulse and the byte to send.

The flags are sticky. Each one clears only after a two-step bus sequence. First, a status read must observe the flag as set. Then the CPU must make a specific access: a data-register access for the transfer and collision flags, or a control-register write for the mode fault. Receive is double buffered: a completed byte moves into a holding buffer that the CPU reads. Transmit is single buffered: a data write goes straight to the engine, and a write made while the engine is shifting is refused and flagged.

Top module: `spi_regfront`

## Requirements
- R1: After a synchronous reset all flags are 0, a status read returns 0x00, and `tx_start` is low.
- R2: Register select 0 is control, 1 is status and 2 is data. The status byte carries transfer complete in bit 7, write collision in bit 6 and mode fault in bit 4. Bits 5 and 3:0 read 0, and reads of the control register and of select 3 return 0x00. Read data appears on `bus_rdata` on the cycle after the read strobe.
- R3: A `xfer_done` pulse sets the transfer-complete flag whether `cfg_master` is 1 or 0.
- R4: The transfer-complete flag clears when a status read that returned it set is followed by a data-register read or write.
- R5: A data write while the engine is busy (`eng_busy` high, or the cycle right after a start) sets the write-collision flag. It produces no `tx_start` and leaves `tx_byte` unchanged.
- R6: The write-collision flag clears when a status read that returned it set is followed by a data-register read or write.
- R7: A `mode_fault` pulse sets the mode-fault flag. The flag clears only after a status read that returned it set, followed by a control write. Data-register accesses leave it set.
- R8: A data write with the engine idle loads `tx_byte` with the written value. In master configuration it also raises `tx_start` for exactly one cycle, on the cycle after the write. In slave configuration `tx_start` stays low.
- R9: A data read returns the byte of the most recent completed transfer that was accepted into the receive buffer.
- R10: A `xfer_done` that arrives while transfer complete is still set is an overrun. The receive buffer keeps the earlier byte.
- R11: A clearing access clears a flag only if the latest status read saw that flag set. A flag that sets after that read survives the access, and a clearing access with no prior status read has no effect.
- R12: When a flag's set event and its clearing access fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Register read strobe, one cycle per access |
| bus_wr | input | 1 | Register write strobe, one cycle per access |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| cfg_master | input | 1 | 1 = master configuration, 0 = slave |
| eng_busy | input | 1 | Shift engine is moving a byte |
| xfer_done | input | 1 | Pulse: a byte finished shifting |
| xfer_rx_byte | input | 8 | Byte received by the finished transfer |
| mode_fault | input | 1 | Pulse: mode fault detected |
| tx_start | output | 1 | Pulse: engine should start sending `tx_byte` |
| tx_byte | output | 8 | Byte handed to the shift engine |

## Verification
Three situations depend on the relative timing of bus accesses and engine events, so they are hard to reach from the ports. The first is losing an arm: the bench reads status while the flag is clear, then raises `xfer_done`, then makes the data access. The second is a set and a clear landing on the same edge: the bench drives a data read and `xfer_done` in the same cycle, after a status read has armed the clear. The third is overrun: the bench issues a second `xfer_done` before clearing the flag, and later reads back the data register to confirm that the first byte survived.

// File: rtl/spi_regfront_pkg.sv
package spi_regfront_pkg;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_DATA = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int FLAG_N   = 3;
  localparam int FL_DONE  = 0;
  localparam int FL_COLL  = 1;
  localparam int FL_FAULT = 2;

  localparam int BIT_DONE  = 7;
  localparam int BIT_COLL  = 6;
  localparam int BIT_FAULT = 4;
endpackage

// File: rtl/spi_flag_seq.sv
module spi_flag_seq (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic stat_rd_i,
  input  logic clr_acc_i,
  output logic flag_o
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o <= 1'b0;
      armed  <= 1'b0;
    end else begin
      if (stat_rd_i)
        armed <= flag_o;
      else if (clr_acc_i)
        armed <= 1'b0;

      if (set_i)
        flag_o <= 1'b1;
      else if (clr_acc_i && armed)
        flag_o <= 1'b0;
    end
  end

  // R12: a set event always leaves the flag set
  p_set_sticks_r12: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_o);

  // R11: a flag only falls after an armed clearing access
  p_clear_needs_arm_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_o) |-> $past(clr_acc_i && armed));
endmodule

// File: rtl/spi_rx_buffer.sv
module spi_rx_buffer #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done_i,
  input  logic              hold_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic [DATA_W-1:0] buf_o
);
  always_ff @(posedge clk) begin
    if (done_i && !hold_i)
      buf_o <= byte_i;
  end

  // R10: an overrun leaves the buffered byte untouched
  p_overrun_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (done_i && hold_i) |=> $stable(buf_o));
endmodule

// File: rtl/spi_tx_gate.sv
module spi_tx_gate #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_data_i,
  input  logic              master_i,
  input  logic              eng_busy_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              coll_o,
  output logic              tx_start_o,
  output logic [DATA_W-1:0] tx_byte_o
);
  logic busy_eff;

  assign busy_eff = eng_busy_i | tx_start_o;
  assign coll_o   = wr_data_i & busy_eff;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_start_o <= 1'b0;
      tx_byte_o  <= '0;
    end else begin
      tx_start_o <= wr_data_i & ~busy_eff & master_i;
      if (wr_data_i && !busy_eff)
        tx_byte_o <= wdata_i;
    end
  end

  // R8: the start pulse lasts one cycle
  p_start_single_r8: assert property (@(posedge clk) disable iff (rst)
    tx_start_o |=> !tx_start_o);

  // R5: a refused write neither starts nor reloads
  p_refused_write_r5: assert property (@(posedge clk) disable iff (rst)
    coll_o |=> (!tx_start_o && $stable(tx_byte_o)));
endmodule

// File: rtl/spi_regfront.sv
module spi_regfront
  import spi_regfront_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [SEL_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              cfg_master,
  input  logic              eng_busy,
  input  logic              xfer_done,
  input  logic [DATA_W-1:0] xfer_rx_byte,
  input  logic              mode_fault,
  output logic              tx_start,
  output logic [DATA_W-1:0] tx_byte
);
  reg_sel_e sel;
  logic rd_stat, rd_data, wr_data, wr_ctrl, acc_data;
  logic coll;
  logic [FLAG_N-1:0] flag_set, flag_clr, flag_q;
  logic [DATA_W-1:0] rx_buf, stat_val;

  assign sel      = reg_sel_e'(bus_addr);
  assign rd_stat  = bus_rd && (sel == SEL_STAT);
  assign rd_data  = bus_rd && (sel == SEL_DATA);
  assign wr_data  = bus_wr && (sel == SEL_DATA);
  assign wr_ctrl  = bus_wr && (sel == SEL_CTRL);
  assign acc_data = rd_data | wr_data;

  spi_tx_gate #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst(rst), .wr_data_i(wr_data), .master_i(cfg_master),
    .eng_busy_i(eng_busy), .wdata_i(bus_wdata), .coll_o(coll),
    .tx_start_o(tx_start), .tx_byte_o(tx_byte)
  );

  spi_rx_buffer #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst(rst), .done_i(xfer_done), .hold_i(flag_q[FL_DONE]),
    .byte_i(xfer_rx_byte), .buf_o(rx_buf)
  );

  always_comb begin
    flag_set           = '0;
    flag_clr           = '0;
    flag_set[FL_DONE]  = xfer_done;
    flag_set[FL_COLL]  = coll;
    flag_set[FL_FAULT] = mode_fault;
    flag_clr[FL_DONE]  = acc_data;
    flag_clr[FL_COLL]  = acc_data;
    flag_clr[FL_FAULT] = wr_ctrl;
  end

  for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
    spi_flag_seq u_flag (
      .clk(clk), .rst(rst), .set_i(flag_set[g]), .stat_rd_i(rd_stat),
      .clr_acc_i(flag_clr[g]), .flag_o(flag_q[g])
    );
  end

  always_comb begin
    stat_val            = '0;
    stat_val[BIT_DONE]  = flag_q[FL_DONE];
    stat_val[BIT_COLL]  = flag_q[FL_COLL];
    stat_val[BIT_FAULT] = flag_q[FL_FAULT];
  end

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else if (bus_rd) begin
      case (sel)
        SEL_STAT: bus_rdata <= stat_val;
        SEL_DATA: bus_rdata <= rx_buf;
        default:  bus_rdata <= '0;
      endcase
    end
  end

  // R7: data accesses never clear the mode fault
  p_fault_kept_r7: assert property (@(posedge clk) disable iff (rst)
    (flag_q[FL_FAULT] && !bus_wr) |=> flag_q[FL_FAULT]);

  // R3: a completed byte raises transfer complete
  p_done_sets_r3: assert property (@(posedge clk) disable iff (rst)
    xfer_done |=> flag_q[FL_DONE]);
endmodule

// File: tb/spi_regfront_bench.sv
module spi_regfront_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic       bus_rd, bus_wr;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       cfg_master, eng_busy, xfer_done, mode_fault;
  logic [7:0] xfer_rx_byte;
  logic       tx_start;
  logic [7:0] tx_byte;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 1'b0;

  always #10 clk = ~clk;

  spi_regfront u_spi_regfront (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cfg_master(cfg_master), .eng_busy(eng_busy), .xfer_done(xfer_done),
    .xfer_rx_byte(xfer_rx_byte), .mode_fault(mode_fault),
    .tx_start(tx_start), .tx_byte(tx_byte)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] v);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic done_pulse(input logic [7:0] v);
    @(negedge clk); xfer_done = 1'b1; xfer_rx_byte = v;
    @(negedge clk); xfer_done = 1'b0;
  endtask

  task automatic expect_stat(input logic [7:0] e, input string req);
    logic [7:0] d;
    rd(2'd1, d);
    check(d == e, req, d, e);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    expect_stat(8'h00, "R1");
    check(tx_start == 1'b0, "R1", tx_start, 0);
    rd(2'd3, d);
    check(d == 8'h00, "R2", d, 0);
    rd(2'd0, d);
    check(d == 8'h00, "R2", d, 0);
  endtask

  task automatic t_master_xfer;
    logic [7:0] d;
    cfg_master = 1'b1;
    wr(2'd2, 8'hA5);
    check(tx_start == 1'b1, "R8", tx_start, 1);
    check(tx_byte == 8'hA5, "R8", tx_byte, 8'hA5);
    eng_busy = 1'b1;
    @(negedge clk);
    check(tx_start == 1'b0, "R8", tx_start, 0);
    repeat (2) @(negedge clk);
    eng_busy = 1'b0;
    done_pulse(8'h3C);
    expect_stat(8'h80, "R3");
    rd(2'd2, d);
    check(d == 8'h3C, "R9", d, 8'h3C);
    expect_stat(8'h00, "R4");
  endtask

  task automatic t_slave_xfer;
    logic [7:0] d;
    cfg_master = 1'b0;
    wr(2'd2, 8'h11);
    check(tx_start == 1'b0, "R8", tx_start, 0);
    check(tx_byte == 8'h11, "R8", tx_byte, 8'h11);
    @(negedge clk);
    check(tx_start == 1'b0, "R8", tx_start, 0);
    done_pulse(8'h22);
    expect_stat(8'h80, "R3");
    wr(2'd2, 8'h33);
    expect_stat(8'h00, "R4");
    rd(2'd2, d);
    check(d == 8'h22, "R9", d, 8'h22);
  endtask

  task automatic t_overrun;
    logic [7:0] d;
    done_pulse(8'h44);
    done_pulse(8'h55);
    expect_stat(8'h80, "R10");
    rd(2'd2, d);
    check(d == 8'h44, "R10", d, 8'h44);
    expect_stat(8'h00, "R4");
    done_pulse(8'h66);
    expect_stat(8'h80, "R3");
    rd(2'd2, d);
    check(d == 8'h66, "R9", d, 8'h66);
  endtask

  task automatic t_collision;
    logic [7:0] d;
    cfg_master = 1'b1;
    eng_busy = 1'b1;
    wr(2'd2, 8'h77);
    check(tx_start == 1'b0, "R5", tx_start, 0);
    check(tx_byte == 8'h33, "R5", tx_byte, 8'h33);
    expect_stat(8'h40, "R5");
    rd(2'd2, d);
    expect_stat(8'h00, "R6");
    eng_busy = 1'b0;
  endtask

  task automatic t_fault;
    logic [7:0] d;
    @(negedge clk); mode_fault = 1'b1;
    @(negedge clk); mode_fault = 1'b0;
    expect_stat(8'h10, "R7");
    rd(2'd2, d);
    wr(2'd2, 8'h33);
    expect_stat(8'h10, "R7");
    wr(2'd0, 8'h00);
    expect_stat(8'h00, "R7");
    @(negedge clk); mode_fault = 1'b1;
    @(negedge clk); mode_fault = 1'b0;
    wr(2'd0, 8'h00);
    expect_stat(8'h10, "R11");
    wr(2'd0, 8'h00);
    expect_stat(8'h00, "R7");
  endtask

  task automatic t_arm_lost;
    logic [7:0] d;
    expect_stat(8'h00, "R11");
    done_pulse(8'h5A);
    rd(2'd2, d);
    expect_stat(8'h80, "R11");
    rd(2'd2, d);
    check(d == 8'h5A, "R9", d, 8'h5A);
    expect_stat(8'h00, "R4");
  endtask

  task automatic t_set_wins;
    logic [7:0] d;
    done_pulse(8'hC3);
    expect_stat(8'h80, "R12");
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 2'd2; xfer_done = 1'b1; xfer_rx_byte = 8'h99;
    @(negedge clk);
    bus_rd = 1'b0; xfer_done = 1'b0;
    check(bus_rdata == 8'hC3, "R12", bus_rdata, 8'hC3);
    expect_stat(8'h80, "R12");
    rd(2'd2, d);
    check(d == 8'hC3, "R10", d, 8'hC3);
    expect_stat(8'h00, "R4");
  endtask

  task automatic finish_run;
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual 0x1 expected 0x0");
    finish_run();
  end

  initial begin
    rst = 1'b1; bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = 8'h00;
    cfg_master = 1'b0; eng_busy = 1'b0; xfer_done = 1'b0; xfer_rx_byte = 8'h00;
    mode_fault = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_master_xfer();
    t_slave_xfer();
    t_overrun();
    t_collision();
    t_fault();
    t_arm_lost();
    t_set_wins();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule